// File: doc/BRIEF.md
# Even-Spread Step Pacer

The block places N step pulses among M iteration slots so that the pulses are spread as evenly as integer arithmetic allows. It keeps a signed error term, adjusts it once per iteration with the classic line-rasterising increment rule, and fires a step in each iteration where that term was positive. A single start strobe loads the two operands. The block then reports busy while it works, emits a registered step pulse for each stepping iteration, and finishes with a one-cycle done pulse.

A build parameter selects the datapath. The default chains a conditional subtract and an add, so one iteration finishes on every clock. The alternative reuses one add/subtract path, so an iteration that steps takes two clocks and one that does not step takes one. Both variants produce the same step pattern.

Top module: `step_pacer`

## Requirements
- R1: While rst_ni is low, and on the first cycles after it is released, step_o, busy_o and done_o are all 0.
- R2: A start_i pulse seen at a rising clock edge while busy_o is 0 and iters_i is non-zero makes busy_o read 1 from that edge onward.
- R3: With SHARED_PATH=0, a run of iters_i = M lasts M cycles. The first iteration's result appears one edge after the run starts. The last iteration's step and the done pulse appear together.
- R4: With SHARED_PATH=1, an iteration that steps takes two cycles and drives its step pulse in the second. A run therefore lasts M + N cycles.
- R5: When steps_i = N is no greater than M, exactly N step pulses occur in a run.
- R6: The error term e starts at 2N - M. Iteration i steps exactly when e > 0 before its update. The update is e := (e > 0 ? e - 2M : e) + 2N.
- R7: The gaps, in iterations, between consecutive step pulses differ from each other by at most one.
- R8: A start with iters_i = 0 yields done_o = 1 in the next cycle, with busy_o and step_o both 0.
- R9: With steps_i = 0 and iters_i > 0, the run lasts M cycles and produces no step pulse.
- R10: start_i is ignored while busy_o is 1, whatever operands accompany it. The running step sequence and its length are unchanged.
- R11: done_o is high for exactly one cycle per run, and busy_o is 0 in that cycle. step_o is only ever 1 in a cycle that follows a cycle with busy_o high.
- R12: For operands with N no greater than M, the error term stays within [-2M, 2N] throughout a run, so it cannot overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, acted on only when idle |
| iters_i | input | W | Iteration count M |
| steps_i | input | W | Step count N, at most M |
| step_o | output | 1 | One-cycle pulse per stepping iteration |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when a run ends |

## Verification
A corrupted error term or constant shows up as a step pulse in the wrong slot. It also breaks the uneven-gap bound or the total step count, and it can do so several iterations after the fault. For that reason the bench compares every cycle of the step stream against a model, not only the totals. A slip in the iteration counter moves done_o, which shows at the end of the same run. A wrong phase in the shared-path variant shifts every later pulse by one cycle, which appears at the very next stepping iteration. Runs attempted with a second start in mid-run expose any leak of the strobe into the loaded state.

// File: rtl/step_pacer_pkg.sv
package step_pacer_pkg;
  // phase of the shared add/subtract datapath
  typedef enum logic {
    PH_EVAL = 1'b0,
    PH_ADD  = 1'b1
  } pacer_phase_e;
endpackage

// File: rtl/pacer_down_cnt.sv
module pacer_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == W'(1));

  // R10
  cnt_never_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/pacer_err_path.sv
module pacer_err_path
  import step_pacer_pkg::*;
#(
  parameter int W           = 8,
  parameter bit SHARED_PATH = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] dx_i,
  input  logic [W-1:0] dy_i,
  input  logic         run_i,
  output logic         iter_done_o,
  output logic         step_now_o
);
  localparam int EW = W + 3;

  logic signed [EW-1:0] err_q, err_d;
  logic [W:0]           dx2_q, dy2_q;
  logic signed [EW-1:0] dx2_s, dy2_s;
  logic                 pos;

  assign dx2_s = $signed({2'b00, dx2_q});
  assign dy2_s = $signed({2'b00, dy2_q});
  assign pos   = !err_q[EW-1] && (err_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
      dx2_q <= '0;
      dy2_q <= '0;
    end else if (load_i) begin
      err_q <= $signed({2'b00, dy_i, 1'b0}) - $signed({3'b000, dx_i});
      dx2_q <= {dx_i, 1'b0};
      dy2_q <= {dy_i, 1'b0};
    end else if (run_i) begin
      err_q <= err_d;
    end
  end

  if (!SHARED_PATH) begin : g_two_adder
    always_comb begin
      err_d       = (pos ? err_q - dx2_s : err_q) + dy2_s;
      iter_done_o = run_i;
      step_now_o  = run_i && pos;
    end
  end else begin : g_shared
    pacer_phase_e phase_q, phase_d;

    always_comb begin
      phase_d     = phase_q;
      err_d       = err_q + dy2_s;
      iter_done_o = 1'b0;
      step_now_o  = 1'b0;
      if (run_i) begin
        if (phase_q == PH_EVAL && pos) begin
          err_d   = err_q - dx2_s;
          phase_d = PH_ADD;
        end else begin
          iter_done_o = 1'b1;
          step_now_o  = (phase_q == PH_ADD);
          phase_d     = PH_EVAL;
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     phase_q <= PH_EVAL;
      else if (load_i) phase_q <= PH_EVAL;
      else             phase_q <= phase_d;
    end
  end

  // R12
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (err_q >= -dx2_s) && (err_q <= dy2_s));
endmodule

// File: rtl/step_pacer.sv
module step_pacer #(
  parameter int W           = 8,
  parameter bit SHARED_PATH = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] iters_i,
  input  logic [W-1:0] steps_i,
  output logic         step_o,
  output logic         busy_o,
  output logic         done_o
);
  logic busy_q, done_q, step_q;
  logic accept, zero_len, load, dec, last, iter_done, step_now;

  assign accept   = start_i && !busy_q;
  assign zero_len = (iters_i == '0);
  assign load     = accept && !zero_len;
  assign dec      = busy_q && iter_done;

  pacer_err_path #(.W(W), .SHARED_PATH(SHARED_PATH)) u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .dx_i       (iters_i),
    .dy_i       (steps_i),
    .run_i      (busy_q),
    .iter_done_o(iter_done),
    .step_now_o (step_now)
  );

  pacer_down_cnt #(.W(W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(iters_i),
    .dec_i     (dec),
    .last_o    (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= 1'b0;
    end else begin
      step_q <= step_now;
      done_q <= (accept && zero_len) || (dec && last);
      if (load)             busy_q <= 1'b1;
      else if (dec && last) busy_q <= 1'b0;
    end
  end

  assign step_o = step_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  // R2
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && (iters_i != '0) |=> busy_o);
  // R11
  done_busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R11
  step_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> $past(busy_o));
endmodule

// File: tb/step_pacer_bench.sv
`timescale 1ns/1ps
module step_pacer_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] iters = '0, steps = '0;
  logic step_a, busy_a, done_a, step_b, busy_b, done_b;

  int tests = 0, fails = 0;
  bit exp_a [0:1023];
  bit exp_b [0:1023];
  bit got_a [0:1023];
  bit got_b [0:1023];

  always #2 clk = ~clk;

  step_pacer #(.W(W), .SHARED_PATH(1'b0)) u_step_pacer (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .iters_i(iters), .steps_i(steps),
    .step_o(step_a), .busy_o(busy_a), .done_o(done_a));

  step_pacer #(.W(W), .SHARED_PATH(1'b1)) u_step_pacer_shared (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .iters_i(iters), .steps_i(steps),
    .step_o(step_b), .busy_o(busy_b), .done_o(done_b));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // model of both datapaths; returns lengths
  task automatic model(input int dx, input int dy, output int na, output int nb);
    int e;
    e = 2*dy - dx; na = 0; nb = 0;
    for (int i = 0; i < dx; i++) begin
      if (e > 0) begin
        exp_a[na] = 1'b1; exp_b[nb] = 1'b0; exp_b[nb+1] = 1'b1; nb += 2; e -= 2*dx;
      end else begin
        exp_a[na] = 1'b0; exp_b[nb] = 1'b0; nb++;
      end
      na++; e += 2*dy;
    end
  endtask

  task automatic run(input int dx, input int dy, input bit poke);
    int na, nb, ca, cb, cyc, mis_a, mis_b, sa, sb, last_idx, gmin, gmax;
    bit da, db;
    model(dx, dy, na, nb);
    @(negedge clk);
    iters = W'(dx); steps = W'(dy); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (dx == 0) begin
      chk(done_a && done_b, "R8 done", int'(done_a) + int'(done_b), 2);
      chk(!busy_a && !busy_b && !step_a && !step_b, "R8 idle", int'(busy_a|busy_b|step_a|step_b), 0);
      @(negedge clk);
      chk(!done_a && !done_b, "R11 single done", int'(done_a|done_b), 0);
      return;
    end
    chk(busy_a && busy_b, "R2 busy", int'(busy_a) + int'(busy_b), 2);
    if (poke) begin
      // R10: second start mid-run with other operands
      start = 1'b1; iters = W'(dx ^ 5) | W'(1); steps = '0;
    end
    ca = 0; cb = 0; cyc = 0; da = 0; db = 0;
    while (!(da && db) && cyc < 2000) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (!da) begin
        got_a[ca] = step_a; ca++;
        if (done_a) begin
          da = 1;
          chk(!busy_a, "R11 busy low at done", int'(busy_a), 0);
        end
      end else chk(!done_a && !step_a, "R11 quiet after done", int'(done_a|step_a), 0);
      if (!db) begin
        got_b[cb] = step_b; cb++;
        if (done_b) begin
          db = 1;
          chk(!busy_b, "R11 busy low at done", int'(busy_b), 0);
        end
      end else chk(!done_b && !step_b, "R11 quiet after done", int'(done_b|step_b), 0);
    end
    @(negedge clk);
    chk(!done_a && !done_b, "R11 single done", int'(done_a|done_b), 0);
    chk(ca == na, "R3 run length", ca, na);
    chk(cb == nb, "R4 run length", cb, nb);
    mis_a = 0; mis_b = 0; sa = 0; sb = 0;
    last_idx = -1; gmin = 100000; gmax = 0;
    for (int i = 0; i < ca && i < na; i++) if (got_a[i] != exp_a[i]) mis_a++;
    for (int i = 0; i < cb && i < nb; i++) if (got_b[i] != exp_b[i]) mis_b++;
    for (int i = 0; i < ca; i++) if (got_a[i]) begin
      sa++;
      if (last_idx >= 0) begin
        if (i - last_idx < gmin) gmin = i - last_idx;
        if (i - last_idx > gmax) gmax = i - last_idx;
      end
      last_idx = i;
    end
    for (int i = 0; i < cb; i++) if (got_b[i]) sb++;
    chk(mis_a == 0, "R6 step placement two-adder", mis_a, 0);
    chk(mis_b == 0, "R6 step placement shared", mis_b, 0);
    chk(sa == dy, "R5 step count two-adder", sa, dy);
    chk(sb == dy, "R5 step count shared", sb, dy);
    if (sa >= 3) chk(gmax - gmin <= 1, "R7 gap spread", gmax - gmin, 1);
    if (dy == 0) chk(sa == 0 && sb == 0 && ca == dx, "R9 no steps", sa + sb, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int dx, dy;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!step_a && !busy_a && !done_a && !step_b && !busy_b && !done_b, "R1 in reset",
        int'(step_a|busy_a|done_a|step_b|busy_b|done_b), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!step_a && !busy_a && !done_a && !step_b && !busy_b && !done_b, "R1 after reset",
        int'(step_a|busy_a|done_a|step_b|busy_b|done_b), 0);
    run(0, 0, 0);    // R8
    run(5, 0, 0);    // R9
    run(1, 1, 0);
    run(7, 7, 0);
    run(10, 3, 0);
    run(8, 4, 1);    // R10
    run(255, 1, 0);
    run(255, 255, 1);
    run(255, 128, 0);
    for (int k = 0; k < 40; k++) begin
      dx = int'($urandom_range(255, 1));
      dy = int'($urandom_range(dx, 0));
      run(dx, dy, k[0]);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule